// File: doc/BRIEF.md
# Decimating Converter Serial Interface Model

This block models the digital side of an oversampling converter whose output rate is a fixed fraction of its master clock. It is a synthesizable stand-in for a real converter in a larger design. A free-running phase counter splits the master clock into output periods. Each period ends in a single-cycle ready strobe. Conversion results are not computed here: they arrive as 24-bit two's complement words on a parallel valid/ready port. The word taken at a period boundary is what a host then shifts out serially with a chip select and a serial clock.

The serial side shifts its word out MSB first. Bits from an upstream device on the serial input follow behind it, so several models can be chained on one data line. Chip select only gates the output-enable. A host may keep it low and use the falling edge of the ready line as the frame marker. A combined sync/power-down input, active low, stops sampling, holds the ready line high and resets the period timing. After release, the data line reads zero until a fixed settling interval has passed. The first valid word is then announced. The serial clock and chip select are sampled on the master clock, so a serial clock edge takes effect on the next master-clock edge.

Intake rules on the parallel port: `smp_ready` is high for exactly one master-clock cycle per period, the boundary cycle. A word moves only when `smp_valid` and `smp_ready` are both high in that cycle. A source that is not valid then is not waited for: the previous word is served again and the next chance comes one period later. An offered word that gets no ready stays at the port.

Top module: `adc_if_model`

## Requirements
- R1: Once settled, the ready line (`drdy`) falls once every DECIM master-clock cycles.
- R2: In steady state `drdy` is high for exactly one master-clock cycle per period and low for the other DECIM-1 cycles.
- R3: With chip select low, each falling edge of `sclk` (seen at the next master-clock edge) shifts the word by one place. `sdo` starts with bit 23 and ends with bit 0, so the word comes out MSB first.
- R4: `sdo_oe` is high exactly while `cs_n` is low. When `cs_n` falls, `sdo` already carries the MSB of the loaded word.
- R5: With `cs_n` held low through a boundary, `sdo` carries the new word's MSB in the first cycle that `drdy` is low.
- R6: Bits sampled from `sdi` on falling edges 1 to 24 appear on `sdo` MSB first during falling edges 24 to 47 of the same read.
- R7: After reset release, and after `sync_n` returns high, `drdy` falls exactly SETTLE_CYC master-clock edges later.
- R8: `smp_ready` is high only in the boundary cycle, and only while `drdy` is high. The word taken is `smp_data` when `smp_valid` is high then. Otherwise the previous word is served again.
- R9: If a boundary arrives while a read is in progress (`cs_n` low and 1 to 23 falling edges since the last load), the read finishes with the old word. The new word is loaded after the 24th edge or when `cs_n` rises.
- R10: One edge after `sync_n` is sampled low, `drdy` is high. While `sync_n` stays low, `smp_ready` stays low.
- R11: `sdo` reads 0 while `sync_n` is low and throughout the settling interval that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_n | input | 1 | Sync/power-down, active low |
| smp_data | input | 24 | Parallel result, two's complement |
| smp_valid | input | 1 | Result on smp_data is valid |
| smp_ready | output | 1 | Result accepted this cycle |
| drdy | output | 1 | Data-ready line; its fall marks a new word |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the upstream device |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for sdo |

## Verification
Two events can fall in the same master-clock cycle: the period-boundary load and a serial clock falling edge that belongs to a read already under way. The bench provokes this by starting reads at a sweep of offsets before the boundary. Some falling edges then land exactly on the load edge, and others land just before or after it. Each trial passes only if all 24 bits read back as the old word. A second read must then return the word that was taken at that boundary, which shows the load was deferred and not lost.

// File: rtl/adc_if_pkg.sv
package adc_if_pkg;
  parameter int unsigned ADC_WORD_W  = 24;
  parameter int unsigned ADC_DECIM   = 32;
  parameter int unsigned ADC_SETTLE  = 2357;
endpackage

// File: rtl/adc_if_timing.sv
module adc_if_timing #(
  parameter int unsigned DECIM      = adc_if_pkg::ADC_DECIM,
  parameter int unsigned SETTLE_CYC = adc_if_pkg::ADC_SETTLE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sync_n,
  output logic tick,
  output logic drdy,
  output logic settling
);
  localparam int unsigned PW = (DECIM > 2) ? $clog2(DECIM) : 1;
  localparam int unsigned SW = $clog2(SETTLE_CYC + 1);
  localparam logic [PW-1:0] PH_LAST = PW'(DECIM - 1);
  localparam logic [SW-1:0] ST_INIT = SW'(SETTLE_CYC);
  localparam logic [SW-1:0] ST_ONE  = SW'(1);

  logic [PW-1:0] phase;
  logic [SW-1:0] settle;

  // boundary: end of settling, or last phase of a running period
  assign tick     = sync_n && ((settle == ST_ONE) || (settle == '0 && phase == PH_LAST));
  assign settling = (settle != '0);
  assign drdy     = settling || (phase == PH_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle <= ST_INIT;
      phase  <= '0;
    end else if (!sync_n) begin
      settle <= ST_INIT;
      phase  <= '0;
    end else if (tick) begin
      settle <= '0;
      phase  <= '0;
    end else if (settling) begin
      settle <= settle - ST_ONE;
    end else begin
      phase <= phase + PW'(1);
    end
  end
endmodule

// File: rtl/adc_if_shifter.sv
module adc_if_shifter #(
  parameter int unsigned WORD_W = adc_if_pkg::ADC_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_n,
  input  logic              tick,
  input  logic              smp_valid,
  input  logic [WORD_W-1:0] smp_data,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              msb
);
  localparam int unsigned CW = $clog2(WORD_W + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(WORD_W);

  logic              sclk_q;
  logic [WORD_W-1:0] sh;
  logic [WORD_W-1:0] word_q;
  logic [CW-1:0]     cnt;
  logic              pend;

  logic              fall;
  logic              busy;
  logic              load_now;
  logic [WORD_W-1:0] new_word;
  logic [WORD_W-1:0] load_val;

  assign fall     = sclk_q && !sclk;
  assign busy     = !cs_n && (cnt != '0) && (cnt < CNT_FULL);
  assign new_word = smp_valid ? smp_data : word_q;
  assign load_now = (tick || pend) && !busy;
  assign load_val = tick ? new_word : word_q;
  assign msb      = sh[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      sh     <= '0;
      word_q <= '0;
      cnt    <= '0;
      pend   <= 1'b0;
    end else begin
      sclk_q <= sclk;
      if (tick) word_q <= new_word;
      if (!sync_n) begin
        pend <= 1'b0;
        cnt  <= '0;
      end else if (load_now) begin
        sh   <= load_val;
        cnt  <= '0;
        pend <= 1'b0;
      end else begin
        if (tick) pend <= 1'b1;
        if (fall && !cs_n) begin
          sh <= {sh[WORD_W-2:0], sdi};
          if (cnt != CNT_FULL) cnt <= cnt + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/adc_if_model.sv
module adc_if_model #(
  parameter int unsigned WORD_W     = adc_if_pkg::ADC_WORD_W,
  parameter int unsigned DECIM      = adc_if_pkg::ADC_DECIM,
  parameter int unsigned SETTLE_CYC = adc_if_pkg::ADC_SETTLE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_n,
  input  logic [WORD_W-1:0] smp_data,
  input  logic              smp_valid,
  output logic              smp_ready,
  output logic              drdy,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe
);
  logic tick;
  logic settling;
  logic msb;

  adc_if_timing #(.DECIM(DECIM), .SETTLE_CYC(SETTLE_CYC)) u_timing (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n),
    .tick(tick), .drdy(drdy), .settling(settling)
  );

  adc_if_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .tick(tick),
    .smp_valid(smp_valid), .smp_data(smp_data),
    .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .msb(msb)
  );

  assign smp_ready = tick;
  assign sdo       = settling ? 1'b0 : msb;
  assign sdo_oe    = !cs_n;
endmodule

// File: rtl/adc_if_checker.sv
module adc_if_checker (
  input logic clk,
  input logic rst_n,
  input logic sync_n,
  input logic smp_ready,
  input logic drdy,
  input logic sdo
);
  a_r8_ready_in_drdy: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready |-> drdy);

  a_r8_ready_then_fall: assert property (@(posedge clk) disable iff (!rst_n)
    smp_ready |=> !drdy);

  a_r10_pd_drdy_high: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n |=> drdy);

  a_r10_pd_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n |-> !smp_ready);

  a_r11_pd_blank: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_n |=> (sdo == 1'b0));
endmodule

bind adc_if_model adc_if_checker u_chk (
  .clk(clk), .rst_n(rst_n), .sync_n(sync_n),
  .smp_ready(smp_ready), .drdy(drdy), .sdo(sdo)
);

// File: tb/test_adc_if_model.sv
`timescale 1ns/1ps
module test_adc_if_model;
  localparam int W      = 24;
  localparam int DECIM  = 128;
  localparam int SETTLE = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_n = 1'b1;
  logic smp_valid = 1'b1;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic sdi = 1'b0;
  logic [W-1:0] smp_data;
  logic smp_ready, drdy, sdo, sdo_oe;

  int checks = 0;
  int errors = 0;
  int idx = 0;
  bit done = 0;

  always #4 clk = ~clk;

  function automatic logic [W-1:0] pat(input int i);
    case (i)
      0: return 24'h800000;
      1: return 24'h7FFFFF;
      2: return 24'h000001;
      3: return 24'hFFFFFF;
      default: return W'(i * 32'h1B3D5) ^ 24'hA5C31E;
    endcase
  endfunction

  assign smp_data = pat(idx);
  always @(posedge clk) if (rst_n && smp_ready && smp_valid) idx <= idx + 1;

  adc_if_model #(.WORD_W(W), .DECIM(DECIM), .SETTLE_CYC(SETTLE)) i_adc_if_model (
    .clk(clk), .rst_n(rst_n), .sync_n(sync_n), .smp_data(smp_data),
    .smp_valid(smp_valid), .smp_ready(smp_ready), .drdy(drdy),
    .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo(sdo), .sdo_oe(sdo_oe)
  );

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_fall(output int n);
    logic prev;
    n = 0;
    prev = drdy;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      n++;
      if (prev && !drdy) return;
      prev = drdy;
    end
  endtask

  task automatic read_bits(input int n, input logic [W-1:0] up, output logic [47:0] got);
    got = '0;
    for (int j = 1; j <= n; j++) begin
      got = {got[46:0], sdo};
      sdi = (j <= W) ? up[W-j] : 1'b0;
      sclk = 1'b1;
      @(negedge clk);
      sclk = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, rdy_at, hi;
    logic [47:0] got;
    logic [W-1:0] w, prev_w;
    repeat (3) @(negedge clk);
    chk("R7 reset drdy", drdy, 1);
    chk("R4 reset oe", sdo_oe, 0);
    chk("R8 reset ready", smp_ready, 0);
    rst_n = 1'b1;
    n = 0; rdy_at = -1;
    for (int k = 0; k < 100 && drdy; k++) begin
      if (smp_ready) rdy_at = n;
      @(negedge clk);
      n++;
    end
    chk("R7 settle after reset", n, SETTLE);
    chk("R8 ready only at boundary", rdy_at, SETTLE - 1);

    // period and pulse width, three periods
    for (int p = 0; p < 3; p++) begin
      n = 0;
      while (!drdy && n < 1000) begin @(negedge clk); n++; end
      chk("R2 low cycles", n, DECIM - 1);
      hi = 0;
      while (drdy && hi < 1000) begin @(negedge clk); hi++; end
      chk("R2 high width", hi, 1);
      chk("R1 period", n + hi, DECIM);
    end

    // framed reads with chip select, several patterns
    for (int p = 0; p < 4; p++) begin
      if (p > 0) wait_fall(n);
      w = pat(idx - 1);
      cs_n = 1'b0; #1;
      chk("R4 oe on cs", sdo_oe, 1);
      chk("R4 msb on cs fall", sdo, w[W-1]);
      @(negedge clk);
      read_bits(W, '0, got);
      chk("R3 word msb first", got[W-1:0], w);
      cs_n = 1'b1; #1;
      chk("R4 oe off", sdo_oe, 0);
      prev_w = w;
    end

    // no valid at boundary: previous word repeats
    smp_valid = 1'b0;
    wait_fall(n);
    smp_valid = 1'b1;
    cs_n = 1'b0;
    @(negedge clk);
    read_bits(W, '0, got);
    chk("R8 repeat when not valid", got[W-1:0], prev_w);
    cs_n = 1'b1;

    // cs held low, daisy chain
    cs_n = 1'b0;
    for (int p = 0; p < 3; p++) begin
      wait_fall(n);
      w = pat(idx - 1);
      chk("R5 msb after drdy fall", sdo, w[W-1]);
      read_bits(2 * W, pat(40 + p), got);
      chk("R6 chained word", got, {w, pat(40 + p)});
    end
    cs_n = 1'b1;

    // boundary during a read: sweep start offsets
    for (int off = 0; off < 8; off++) begin
      wait_fall(n);
      w = pat(idx - 1);
      repeat (DECIM - 16 + off) @(negedge clk);
      cs_n = 1'b0;
      read_bits(W, '0, got);
      chk("R9 read not disturbed", got[W-1:0], w);
      cs_n = 1'b1;
      @(negedge clk);
      cs_n = 1'b0;
      read_bits(W, '0, got);
      chk("R9 deferred word loaded", got[W-1:0], pat(idx - 1));
      cs_n = 1'b1;
    end

    // sync / power-down
    wait_fall(n);
    cs_n = 1'b0;
    repeat (5) @(negedge clk);
    sync_n = 1'b0;
    @(negedge clk);
    chk("R10 drdy high in pd", drdy, 1);
    chk("R11 sdo blank in pd", sdo, 0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R10 no ready in pd", smp_ready, 0);
    end
    sync_n = 1'b1;
    n = 0; hi = 0;
    for (int k = 0; k < 100 && drdy; k++) begin
      if (sdo !== 1'b0) hi++;
      @(negedge clk);
      n++;
    end
    chk("R7 settle after sync", n, SETTLE);
    chk("R11 blank during settle", hi, 0);
    chk("R11 valid after settle", sdo, pat(idx - 1) >> (W - 1));
    cs_n = 1'b1;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule